// File: doc/BRIEF.md
# Quick DMA Channel Trigger Controller

This block sits between a register bus and a transfer engine and manages a small group of quick DMA channels. Each channel is pointed at one parameter set and at one 32-bit word inside that set. Parameter memory is not held here. The block watches the same write bus that fills that memory. When software writes the chosen word of a channel's set and the channel is enabled, the channel raises an event toward the transfer engine.

Each channel has one event flag. A trigger that arrives while the flag is still set is recorded as a missed event and does not produce a second request. Pending flags are offered to the transfer engine one at a time, lowest channel first. When the engine finishes a transfer it returns a completion code. That code sets a bit in a 64-bit pending-interrupt vector, which is read and cleared as two 32-bit halves.

Top module: `qdma_trig_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every map register, the enable mask, the event flags, the missed flags and both pending halves read zero, and `trig_valid` is low.
- R2: The map register of channel c sits at byte address 0x200 + 4*c. It keeps the parameter-set number in bits 13:5 and the word index in bits 4:2, and every other bit reads back as zero.
- R3: A write to address 0x4000 + 32*set + 4*word matches an enabled channel when the channel's map is non-zero and equal to that set and word. The channel's event flag is set at that clock edge. From the next cycle `trig_valid` is high, and `trig_chan` and `trig_set` name the channel and its set.
- R4: No event is raised for a disabled channel, for a channel whose map is zero (unmapped), or for a write to a different word of the mapped set.
- R5: Writing ones to 0x304 sets enable bits, and writing ones to 0x308 clears them. Zero bits leave enables unchanged. The mask reads at 0x300.
- R6: A match on a channel whose event flag is already set sets that channel's missed flag (read at 0x318) and issues no second request. The channel is then accepted only once.
- R7: With several flags set, the lowest-numbered channel is offered. Its flag clears at the edge where `trig_valid` and `trig_ready` are both high. Event flags read at 0x310.
- R8: Writing ones to 0x314 clears event flags, and writing ones to 0x31C clears missed flags. Zero bits have no effect.
- R9: A returned completion code below 32 sets that bit of the low pending half (read 0x400). Codes 32 to 63 set bit code-32 of the high half (read 0x404).
- R10: Writing ones to 0x480 or 0x484 clears the matching bits of the low or high pending half. When a set and a clear of the same bit fall in one cycle, the bit ends set.
- R11: A write anywhere in the parameter window that matches no channel, or to an address outside the register map, changes no register and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register and parameter bus |
| reg_addr | input | 16 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| trig_valid | output | 1 | A channel event is offered to the transfer engine |
| trig_chan | output | 3 | Channel of the offered event |
| trig_set | output | 9 | Parameter set mapped to the offered channel |
| trig_ready | input | 1 | Transfer engine accepts the offered event |
| cmpl_valid | input | 1 | A completion code is returned |
| cmpl_code | input | 6 | Returned completion code |

## Verification
Directed cases cover several trigger patterns. A single enabled channel hit on its word separates correct set and word decoding from near misses on the neighbouring word, a disabled channel and an unmapped channel. A repeated hit before acceptance separates missed-event recording from double issue. Two channels pending with the engine ready exposes the service order. Around these, seeded random traffic mixes parameter writes over a few sets with remaps, enable changes, flag clears, random back-pressure and completion codes in both halves. Outputs are compared every cycle, and all registers are read back at intervals.

// File: rtl/qdt_pkg.sv
// Package: shared register offsets, field positions and the channel map type
// for the quick DMA trigger controller. Assumes a byte-addressed 32-bit bus.
package qdt_pkg;
    localparam int SET_W        = 9;
    localparam int WORD_W       = 3;
    localparam int NUM_SETS     = 512;
    localparam int SET_BYTES    = 32;
    localparam int MAP_WORD_LSB = 2;
    localparam int MAP_SET_LSB  = 5;

    localparam int OFS_MAP       = 'h0200;
    localparam int OFS_EN_STAT   = 'h0300;
    localparam int OFS_EN_SET    = 'h0304;
    localparam int OFS_EN_CLR    = 'h0308;
    localparam int OFS_EVT_STAT  = 'h0310;
    localparam int OFS_EVT_CLR   = 'h0314;
    localparam int OFS_MISS_STAT = 'h0318;
    localparam int OFS_MISS_CLR  = 'h031C;
    localparam int OFS_PEND_RD   = 'h0400;
    localparam int OFS_PEND_CLR  = 'h0480;
    localparam int OFS_PSET      = 'h4000;

    typedef struct packed {
        logic [SET_W-1:0]  set;
        logic [WORD_W-1:0] word;
    } qmap_t;
endpackage

// File: rtl/qdt_match.sv
// Module: decodes a write into the parameter window and compares it with
// every channel map. Assumes the window starts at OFS_PSET and is
// NUM_SETS*SET_BYTES long. A map of all zeros means the channel is unmapped.
module qdt_match
    import qdt_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 16
) (
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  qmap_t [NUM_CH-1:0]    maps,
    input  logic  [NUM_CH-1:0]    enable,
    output logic  [NUM_CH-1:0]    hit
);
    localparam logic [ADDR_W:0] WIN_BASE = (ADDR_W+1)'(OFS_PSET);
    localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(NUM_SETS * SET_BYTES);

    logic [ADDR_W:0]   off;
    logic              in_win;
    logic [SET_W-1:0]  w_set;
    logic [WORD_W-1:0] w_word;
    logic              unused_low;

    // Offset into the window and the set and word it addresses.
    always_comb begin
        off    = {1'b0, addr} - WIN_BASE;
        in_win = wr_en && ({1'b0, addr} >= WIN_BASE) && (off < WIN_SPAN);
        w_set  = off[MAP_SET_LSB +: SET_W];
        w_word = off[MAP_WORD_LSB +: WORD_W];
    end
    assign unused_low = ^off[1:0];

    // Per-channel comparator.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign hit[c] = in_win && enable[c] && (maps[c] != '0)
                        && (maps[c].set == w_set) && (maps[c].word == w_word);
    end
endmodule

// File: rtl/qdt_pick.sv
// Module: fixed-priority selector; reports the lowest set request bit.
// Assumes NUM_CH >= 2.
module qdt_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [CH_W-1:0]   idx
);
    // Scan from the top so the lowest request is assigned last.
    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/qdt_pending.sv
// Module: completion-code pending vector, cleared by write-one-to-clear per
// DATA_W-wide half. A set in the same cycle as a clear of that bit wins.
// Assumes 2**CODE_W is a multiple of DATA_W.
module qdt_pending #(
    parameter int CODE_W  = 6,
    parameter int DATA_W  = 32,
    localparam int NUM_CODES = 1 << CODE_W,
    localparam int NUM_HALF  = NUM_CODES / DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [CODE_W-1:0]    set_code,
    input  logic [NUM_HALF-1:0]  clr_sel,
    input  logic [DATA_W-1:0]    clr_mask,
    output logic [NUM_CODES-1:0] pend
);
    logic [NUM_CODES-1:0] set_vec;
    logic [NUM_CODES-1:0] clr_vec;

    // Decode the returned code into a one-bit set vector.
    assign set_vec = set_valid ? (NUM_CODES'(1) << set_code) : '0;

    // Spread the clear mask onto the selected half.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_clr
        assign clr_vec[h*DATA_W +: DATA_W] = clr_sel[h] ? clr_mask : '0;
    end

    // Pending state: clear first, then set, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/qdma_trig_ctrl.sv
// Module: quick DMA channel trigger controller. Holds channel maps, enables,
// event and missed flags, and the completion pending vector. Raises one event
// at a time to a transfer engine with a valid/ready handshake. Assumes
// DATA_W = 32 and NUM_CH <= DATA_W. Reads are combinational on reg_addr.
module qdma_trig_ctrl
    import qdt_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 6,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int NUM_HALF = (1 << CODE_W) / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trig_valid,
    output logic [CH_W-1:0]   trig_chan,
    output logic [SET_W-1:0]  trig_set,
    input  logic              trig_ready,
    input  logic              cmpl_valid,
    input  logic [CODE_W-1:0] cmpl_code
);
    qmap_t [NUM_CH-1:0]      maps_q;
    logic  [NUM_CH-1:0]      en_q, evt_q, miss_q;
    logic  [NUM_CH-1:0]      hit, acc_vec;
    logic  [NUM_CH-1:0]      wmask;
    logic  [NUM_HALF-1:0]    pclr_sel;
    logic  [(1<<CODE_W)-1:0] pend_vec;

    // Write-address decodes for the flag registers.
    logic we_en_set, we_en_clr, we_evt_clr, we_miss_clr;
    assign we_en_set   = reg_we && (reg_addr == ADDR_W'(OFS_EN_SET));
    assign we_en_clr   = reg_we && (reg_addr == ADDR_W'(OFS_EN_CLR));
    assign we_evt_clr  = reg_we && (reg_addr == ADDR_W'(OFS_EVT_CLR));
    assign we_miss_clr = reg_we && (reg_addr == ADDR_W'(OFS_MISS_CLR));
    assign wmask       = reg_wdata[NUM_CH-1:0];

    qdt_match #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_match (
        .wr_en(reg_we), .addr(reg_addr), .maps(maps_q), .enable(en_q), .hit(hit)
    );

    qdt_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req(evt_q), .any(trig_valid), .idx(trig_chan)
    );

    // Set number of the channel on offer.
    assign trig_set = maps_q[trig_chan].set;

    // One-hot accept of the offered channel.
    assign acc_vec = (trig_valid && trig_ready) ? (NUM_CH'(1) << trig_chan) : '0;

    // Map registers, one per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                maps_q[c] <= '0;
            end else if (reg_we && reg_addr == ADDR_W'(OFS_MAP + 4*c)) begin
                maps_q[c].set  <= reg_wdata[MAP_SET_LSB +: SET_W];
                maps_q[c].word <= reg_wdata[MAP_WORD_LSB +: WORD_W];
            end
        end
    end

    // Enable mask with separate set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (we_en_set) en_q <= en_q | wmask;
        else if (we_en_clr) en_q <= en_q & ~wmask;
    end

    // Event flags: set by a fresh hit, cleared by accept or software.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~acc_vec & ~(we_evt_clr ? wmask : '0)) | (hit & ~evt_q);
    end

    // Missed flags: set by a hit on a busy channel, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_q <= '0;
        else        miss_q <= (miss_q & ~(we_miss_clr ? wmask : '0)) | (hit & evt_q);
    end

    // Select the pending half addressed by a clear write.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_pclr
        assign pclr_sel[h] = reg_we && (reg_addr == ADDR_W'(OFS_PEND_CLR + 4*h));
    end

    qdt_pending #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_valid(cmpl_valid), .set_code(cmpl_code),
        .clr_sel(pclr_sel), .clr_mask(reg_wdata), .pend(pend_vec)
    );

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(OFS_MAP + 4*c))
                reg_rdata = DATA_W'({maps_q[c].set, maps_q[c].word, 2'b00});
        end
        for (int h = 0; h < NUM_HALF; h++) begin
            if (reg_addr == ADDR_W'(OFS_PEND_RD + 4*h))
                reg_rdata = pend_vec[h*DATA_W +: DATA_W];
        end
        if (reg_addr == ADDR_W'(OFS_EN_STAT))   reg_rdata = DATA_W'(en_q);
        if (reg_addr == ADDR_W'(OFS_EVT_STAT))  reg_rdata = DATA_W'(evt_q);
        if (reg_addr == ADDR_W'(OFS_MISS_STAT)) reg_rdata = DATA_W'(miss_q);
    end
endmodule

// File: rtl/qdma_trig_ctrl_chk.sv
// Checker: temporal properties of the trigger controller, bound to the top.
module qdma_trig_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 6,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trig_valid,
    input logic                   trig_ready,
    input logic [CH_W-1:0]        trig_chan,
    input logic [NUM_CH-1:0]      evt_flags,
    input logic [(1<<CODE_W)-1:0] pend,
    input logic                   cmpl_valid,
    input logic [CODE_W-1:0]      cmpl_code
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!trig_valid && pend == '0));

    assert_offer_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> evt_flags[trig_chan]);

    assert_offer_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> ((evt_flags & ((NUM_CH'(1) << trig_chan) - NUM_CH'(1))) == '0));

    assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_ready) |=> !evt_flags[$past(trig_chan)]);

    assert_code_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> pend[$past(cmpl_code)]);
endmodule

bind qdma_trig_ctrl qdma_trig_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_chan(trig_chan), .evt_flags(evt_q), .pend(pend_vec),
    .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code)
);

// File: tb/qdma_trig_ctrl_tb.sv
module qdma_trig_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [15:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        trig_valid;
    logic [2:0]  trig_chan;
    logic [8:0]  trig_set;
    logic        trig_ready = 0;
    logic        cmpl_valid = 0;
    logic [5:0]  cmpl_code = 0;

    int n_chk = 0, n_fail = 0;

    // Reference state kept from the requirements.
    logic [11:0] m_map [8];
    logic [7:0]  m_en, m_evt, m_miss;
    logic [63:0] m_pend;

    always #2 clk = ~clk;

    qdma_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_valid(trig_valid),
        .trig_chan(trig_chan), .trig_set(trig_set), .trig_ready(trig_ready),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int low_chan(input logic [7:0] f);
        int p = -1;
        for (int i = 7; i >= 0; i--) if (f[i]) p = i;
        return p;
    endfunction

    // Next reference state for the inputs currently driven.
    task automatic model_step();
        logic [7:0]  n_en = m_en, n_evt = m_evt, n_miss = m_miss;
        logic [63:0] n_pend = m_pend;
        logic [11:0] n_map [8];
        int p = low_chan(m_evt);
        for (int c = 0; c < 8; c++) n_map[c] = m_map[c];
        if (p >= 0 && trig_ready) n_evt[p] = 1'b0;
        if (reg_we) begin
            if (reg_addr[15:14] == 2'b01) begin
                for (int c = 0; c < 8; c++)
                    if (m_en[c] && m_map[c] != 0 && m_map[c][11:3] == reg_addr[13:5]
                        && m_map[c][2:0] == reg_addr[4:2]) begin
                        if (m_evt[c]) n_miss[c] = 1'b1; else n_evt[c] = 1'b1;
                    end
            end
            for (int c = 0; c < 8; c++)
                if (reg_addr == 16'h0200 + 16'(4*c)) n_map[c] = {reg_wdata[13:5], reg_wdata[4:2]};
            case (reg_addr)
                16'h0304: n_en   = m_en | reg_wdata[7:0];
                16'h0308: n_en   = m_en & ~reg_wdata[7:0];
                16'h0314: n_evt  = n_evt & ~reg_wdata[7:0];
                16'h031C: n_miss = n_miss & ~reg_wdata[7:0];
                16'h0480: n_pend[31:0]  = m_pend[31:0] & ~reg_wdata;
                16'h0484: n_pend[63:32] = m_pend[63:32] & ~reg_wdata;
                default: ;
            endcase
        end
        if (cmpl_valid) n_pend[cmpl_code] = 1'b1;
        m_en = n_en; m_evt = n_evt; m_miss = n_miss; m_pend = n_pend;
        for (int c = 0; c < 8; c++) m_map[c] = n_map[c];
    endtask

    // One clock: update the reference, then compare the trigger outputs.
    task automatic cyc(input string tag);
        int p;
        model_step();
        @(posedge clk); #1;
        p = low_chan(m_evt);
        chk(tag, "trig_valid", 64'(trig_valid), 64'(p >= 0));
        if (p >= 0) begin
            chk(tag, "trig_chan", 64'(trig_chan), 64'(p));
            chk(tag, "trig_set", 64'(trig_set), 64'(m_map[p][11:3]));
        end
    endtask

    task automatic idle();
        reg_we = 0; trig_ready = 0; cmpl_valid = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        cyc(tag);
        reg_we = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        reg_we = 0; reg_addr = a; #1;
        chk(tag, $sformatf("read %h", a), 64'(reg_rdata), 64'(exp));
    endtask

    task automatic check_regs(input string tag);
        for (int c = 0; c < 8; c++) rd(16'h0200 + 16'(4*c), 32'({m_map[c], 2'b00}), tag);
        rd(16'h0300, 32'(m_en), tag);
        rd(16'h0310, 32'(m_evt), tag);
        rd(16'h0318, 32'(m_miss), tag);
        rd(16'h0400, m_pend[31:0], tag);
        rd(16'h0404, m_pend[63:32], tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 8; c++) m_map[c] = 0;
        m_en = 0; m_evt = 0; m_miss = 0; m_pend = 0;
        // Reset with stray inputs held; reset must dominate.
        reg_we = 1; reg_addr = 16'h0304; reg_wdata = 32'hFF; cmpl_valid = 1; cmpl_code = 6'd9;
        repeat (3) @(posedge clk);
        #1; idle(); rst_n = 1;
        // R1: everything zero after reset
        chk("R1", "trig_valid", 64'(trig_valid), 64'd0);
        check_regs("R1");

        // R2: map fields and masking of other bits
        wr(16'h020C, 32'hFFFF_FFFF, "R2");
        rd(16'h020C, 32'h0000_3FFC, "R2");
        wr(16'h020C, 32'h0, "R2");
        rd(16'h020C, 32'h0, "R2");

        // R5: enable set and clear strobes
        wr(16'h0304, 32'h0F, "R5");
        wr(16'h0308, 32'h05, "R5");
        rd(16'h0300, 32'h0A, "R5");
        wr(16'h0308, 32'hFF, "R5");

        // R3: channel 1 on set 7 word 3
        wr(16'h0204, (32'd7 << 5) | (32'd3 << 2), "R3");
        wr(16'h0304, 32'h02, "R3");
        wr(16'h4000 + 16'd7*32 + 16'd12, 32'h1234, "R3");
        chk("R3", "offered channel", 64'(trig_chan), 64'd1);
        chk("R3", "offered set", 64'(trig_set), 64'd7);

        // R6: second hit while pending is recorded as missed
        wr(16'h4000 + 16'd7*32 + 16'd12, 32'h5678, "R6");
        rd(16'h0318, 32'h02, "R6");
        trig_ready = 1; cyc("R6");
        trig_ready = 0;
        chk("R6", "single issue", 64'(trig_valid), 64'd0);

        // R8: clear missed flag
        wr(16'h031C, 32'h02, "R8");
        rd(16'h0318, 32'h0, "R8");

        // R4: neighbouring word, disabled channel, unmapped channel
        wr(16'h4000 + 16'd7*32 + 16'd8, 32'h1, "R4");
        chk("R4", "neighbour word", 64'(trig_valid), 64'd0);
        wr(16'h0208, (32'd7 << 5) | (32'd3 << 2), "R4");
        wr(16'h4000 + 16'd7*32 + 16'd12, 32'h1, "R4");
        rd(16'h0310, 32'h02, "R4");
        trig_ready = 1; cyc("R4"); trig_ready = 0;
        wr(16'h0304, 32'h01, "R4");
        wr(16'h4000, 32'h1, "R4");
        rd(16'h0310, 32'h0, "R4");

        // R7: two pending channels served lowest first
        wr(16'h0214, (32'd2 << 5) | (32'd5 << 2), "R7");
        wr(16'h0208, (32'd2 << 5) | (32'd5 << 2), "R7");
        wr(16'h0304, 32'h24, "R7");
        wr(16'h4000 + 16'd2*32 + 16'd20, 32'h0, "R7");
        rd(16'h0310, 32'h24, "R7");
        chk("R7", "first channel", 64'(trig_chan), 64'd2);
        trig_ready = 1; cyc("R7");
        chk("R7", "second channel", 64'(trig_chan), 64'd5);
        cyc("R7"); trig_ready = 0;
        chk("R7", "drained", 64'(trig_valid), 64'd0);

        // R8: software clear of an event flag
        wr(16'h4000 + 16'd2*32 + 16'd20, 32'h0, "R8");
        wr(16'h0314, 32'h24, "R8");
        rd(16'h0310, 32'h0, "R8");

        // R9 and R10: codes in both halves, set wins over clear
        cmpl_valid = 1; cmpl_code = 6'd3; cyc("R9");
        cmpl_code = 6'd40; cyc("R9"); cmpl_valid = 0;
        rd(16'h0400, 32'h8, "R9");
        rd(16'h0404, 32'h100, "R9");
        cmpl_valid = 1; cmpl_code = 6'd40;
        wr(16'h0484, 32'h100, "R10");
        cmpl_valid = 0;
        rd(16'h0404, 32'h100, "R10");
        wr(16'h0484, 32'h100, "R10");
        wr(16'h0480, 32'hFFFF_FFFF, "R10");
        rd(16'h0400, 32'h0, "R10");
        rd(16'h0404, 32'h0, "R10");

        // R11: unmatched window write and unmapped address
        wr(16'h4000 + 16'd300*32 + 16'd4, 32'hFFFF_FFFF, "R11");
        wr(16'h0100, 32'hFFFF_FFFF, "R11");
        wr(16'h0320, 32'hFFFF_FFFF, "R11");
        check_regs("R11");

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom_range(0, 9));
            reg_we = 1;
            reg_wdata = $urandom;
            case (op)
                0, 1, 2, 3: reg_addr = 16'h4000 + 16'($urandom_range(0, 3) * 32) + 16'($urandom_range(0, 7) * 4);
                4: begin
                    reg_addr = 16'h0200 + 16'($urandom_range(0, 7) * 4);
                    reg_wdata = ($urandom_range(0, 5) == 0) ? 32'h0
                              : (32'($urandom_range(0, 3)) << 5) | (32'($urandom_range(0, 7)) << 2);
                end
                5: reg_addr = 16'h0304;
                6: reg_addr = ($urandom_range(0, 1) == 0) ? 16'h0308 : 16'h0314;
                7: reg_addr = 16'h031C;
                8: reg_addr = ($urandom_range(0, 1) == 0) ? 16'h0480 : 16'h0484;
                default: reg_we = 0;
            endcase
            trig_ready = ($urandom_range(0, 1) == 1);
            cmpl_valid = ($urandom_range(0, 2) == 0);
            cmpl_code  = 6'($urandom);
            cyc("R3 random");
            if (n % 32 == 31) begin
                idle();
                check_regs("R7 random");
            end
        end
        idle();
        check_regs("R9 final");
        summary();
    end
endmodule